// File: doc/BRIEF.md
# Configurable Five-Input Logic Slice

This block is a small programmable logic cell. It holds two 16-entry truth tables, table A and table B. Four shared user inputs address both tables, so each table yields any Boolean function of those four inputs. A fifth input chooses between the two table results, so the slice can produce any function of five inputs. Two outputs are provided. `out_x` carries the table A result. `out_y` carries the five-input result.

Each output passes through its own flip-flop. Each flip-flop has a clock enable and a synchronous set/reset. A mode bit per output chooses whether the output shows the flip-flop or the direct table result.

All truth tables and mode bits live in a configuration shift chain. The chain is loaded one bit per clock while `cfg_en` is high. There is no back-pressure: every cycle with `cfg_en` high consumes `cfg_bit`. The user outputs are meaningful only once the full 35-bit stream has been shifted in and `cfg_en` has returned low.

Top module: `lut_slice`

## Requirements
- R1: While `rst_n` is low, the chain and both output flip-flops clear to 0. With an all-zero configuration, both outputs read 0 after reset.
- R2: Each clock with `cfg_en` high shifts `cfg_bit` into the chain. After 35 such clocks the first bit sent is bit 15 of table A. The stream order is: table A bits 15 down to 0, then table B bits 15 down to 0, then bypass-X, then bypass-Y, then the reset value.
- R3: When bypass-X is 1, `out_x` equals bit `lut_in` of table A, combinationally.
- R4: When bypass-Y is 1, `out_y` equals bit `lut_in` of table B if `sel5` is 1, and bit `lut_in` of table A if `sel5` is 0, combinationally.
- R5: When a bypass bit is 0, that output shows its flip-flop. With `ce` high, `sr` low and `cfg_en` low, the flip-flop captures the direct result on the clock edge.
- R6: With `ce` low, `sr` low and `cfg_en` low, both flip-flops keep their value.
- R7: `sr` high with `cfg_en` low loads the reset-value mode bit into both flip-flops on the next edge, whatever `ce` is.
- R8: While `cfg_en` is high, both flip-flops hold their value and `ce` and `sr` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_bit | input | 1 | Serial configuration data |
| lut_in | input | 4 | Truth-table address shared by both tables |
| sel5 | input | 1 | Fifth input, selects table B when high |
| ce | input | 1 | Flip-flop clock enable |
| sr | input | 1 | Synchronous set/reset to the configured value |
| out_x | output | 1 | Table A function, registered or direct |
| out_y | output | 1 | Five-input function, registered or direct |

## Verification
The bench builds the slice with its default table width of four address bits. This keeps the stream at 35 bits, so many random configurations can be loaded in a short run. It also keeps the input space at 32 combinations, so every combination of `lut_in` and `sel5` is compared against a reference for each table pair. Directed loads cover all-zero, all-one and alternating tables, both reset values, and a reload while the flip-flops are expected to hold.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;
  localparam int MODE_BITS = 3;

  typedef struct packed {
    logic byp_x;
    logic byp_y;
    logic rst_val;
  } slice_mode_t;
endpackage

// File: rtl/cfg_chain.sv
module cfg_chain #(
  parameter int LEN = 35
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           shift_in,
  output logic [LEN-1:0] bits
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bits <= '0;
    else if (shift_en)
      bits <= {bits[LEN-2:0], shift_in};
  end
endmodule

// File: rtl/lut_read.sv
module lut_read #(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [DEPTH-1:0]  table_bits,
  input  logic [ADDR_W-1:0] addr,
  output logic              value
);
  assign value = table_bits[addr];
endmodule

// File: rtl/out_cell.sv
module out_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic sr,
  input  logic ce,
  input  logic rst_val,
  input  logic bypass,
  input  logic d,
  output logic q,
  output logic y
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= 1'b0;
    else if (!hold) begin
      if (sr)
        q <= rst_val;
      else if (ce)
        q <= d;
    end
  end

  assign y = bypass ? d : q;
endmodule

// File: rtl/lut_slice.sv
module lut_slice
  import lut_slice_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_bit,
  input  logic [ADDR_W-1:0] lut_in,
  input  logic              sel5,
  input  logic              ce,
  input  logic              sr,
  output logic              out_x,
  output logic              out_y
);
  localparam int TT        = 1 << ADDR_W;
  localparam int CHAIN_LEN = 2 * TT + MODE_BITS;

  logic [CHAIN_LEN-1:0] chain_w;
  logic [1:0][TT-1:0]   tables;
  logic [1:0]           lut_val;
  logic [1:0]           cell_d;
  logic [1:0]           cell_q;
  logic [1:0]           cell_y;
  logic [1:0]           cell_byp;
  slice_mode_t          mode_r;

  cfg_chain #(.LEN(CHAIN_LEN)) u_chain (
    .clk(clk), .rst_n(rst_n), .shift_en(cfg_en),
    .shift_in(cfg_bit), .bits(chain_w)
  );

  // table A sits at the top of the chain (first bits sent), table B below it
  assign tables[0] = chain_w[CHAIN_LEN-1 -: TT];
  assign tables[1] = chain_w[CHAIN_LEN-1-TT -: TT];
  assign mode_r    = slice_mode_t'(chain_w[MODE_BITS-1:0]);

  for (genvar i = 0; i < 2; i++) begin : g_lut
    lut_read #(.ADDR_W(ADDR_W)) u_lut (
      .table_bits(tables[i]), .addr(lut_in), .value(lut_val[i])
    );
  end

  assign cell_d[0]   = lut_val[0];
  assign cell_d[1]   = sel5 ? lut_val[1] : lut_val[0];
  assign cell_byp[0] = mode_r.byp_x;
  assign cell_byp[1] = mode_r.byp_y;

  for (genvar i = 0; i < 2; i++) begin : g_cell
    out_cell u_cell (
      .clk(clk), .rst_n(rst_n), .hold(cfg_en), .sr(sr), .ce(ce),
      .rst_val(mode_r.rst_val), .bypass(cell_byp[i]), .d(cell_d[i]),
      .q(cell_q[i]), .y(cell_y[i])
    );
  end

  assign out_x = cell_y[0];
  assign out_y = cell_y[1];
endmodule

// File: rtl/lut_slice_chk.sv
module lut_slice_chk
  import lut_slice_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_en,
  input logic        cfg_bit,
  input logic        ce,
  input logic        sr,
  input logic        chain_lsb,
  input slice_mode_t mode,
  input logic [1:0]  d,
  input logic [1:0]  q,
  input logic        out_x,
  input logic        out_y
);
  assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> chain_lsb == $past(cfg_bit));

  assert_direct_x_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode.byp_x |-> out_x == d[0]);

  assert_direct_y_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode.byp_y |-> out_y == d[1]);

  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !sr && ce) |=> q == $past(d));

  assert_reg_view_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.byp_x && !mode.byp_y) |-> (out_x == q[0] && out_y == q[1]));

  assert_ce_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !sr && !ce) |=> $stable(q));

  assert_sr_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && sr) |=> q == {2{$past(mode.rst_val)}});

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> $stable(q));
endmodule

bind lut_slice lut_slice_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
  .ce(ce), .sr(sr), .chain_lsb(chain_w[0]), .mode(mode_r),
  .d(cell_d), .q(cell_q), .out_x(out_x), .out_y(out_y)
);

// File: tb/sim_lut_slice.sv
module sim_lut_slice;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0, cfg_bit = 1'b0;
  logic [3:0] lut_in = '0;
  logic       sel5 = 1'b0, ce = 1'b0, sr = 1'b0;
  logic       out_x, out_y;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  lut_slice u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .lut_in(lut_in), .sel5(sel5), .ce(ce), .sr(sr),
    .out_x(out_x), .out_y(out_y)
  );

  function automatic logic ref_x(input logic [15:0] a, input logic [3:0] i);
    return a[i];
  endfunction

  function automatic logic ref_y(input logic [15:0] a, input logic [15:0] b,
                                 input logic s, input logic [3:0] i);
    return s ? b[i] : a[i];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  // stream: A[15..0], B[15..0], bypass-X, bypass-Y, reset value
  task automatic load(input logic [15:0] a, input logic [15:0] b,
                      input logic bx, input logic by, input logic rv);
    logic [34:0] s;
    s = {a, b, bx, by, rv};
    for (int k = 34; k >= 0; k--) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      cfg_bit = s[k];
    end
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  task automatic sweep(input string req_x, input string req_y,
                       input logic [15:0] a, input logic [15:0] b);
    for (int c = 0; c < 32; c++) begin
      lut_in = c[3:0];
      sel5   = c[4];
      #1;
      check(req_x, out_x, ref_x(a, lut_in));
      check(req_y, out_y, ref_y(a, b, sel5, lut_in));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] ta, tb;
    logic        e;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state, registered mode with zeros
    check("R1", out_x, 1'b0);
    check("R1", out_y, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", out_x, 1'b0);
    check("R1", out_y, 1'b0);

    // R2/R3/R4: directed tables in direct mode
    load(16'hFFFF, 16'h0000, 1'b1, 1'b1, 1'b0);
    sweep("R3", "R4", 16'hFFFF, 16'h0000);
    load(16'hA5C3, 16'h5A3C, 1'b1, 1'b1, 1'b0);
    sweep("R2", "R4", 16'hA5C3, 16'h5A3C);
    load(16'h8001, 16'h7FFE, 1'b1, 1'b1, 1'b1);
    sweep("R2", "R4", 16'h8001, 16'h7FFE);
    // random tables
    for (int r = 0; r < 20; r++) begin
      ta = 16'($urandom);
      tb = 16'($urandom);
      load(ta, tb, 1'b1, 1'b1, 1'b0);
      sweep("R3", "R4", ta, tb);
    end

    // registered mode, reset value 1
    ta = 16'($urandom);
    tb = 16'($urandom);
    load(ta, tb, 1'b0, 1'b0, 1'b1);
    ce = 1'b1;
    for (int r = 0; r < 24; r++) begin
      lut_in = 4'($urandom);
      sel5   = 1'($urandom);
      @(negedge clk);
      check("R5", out_x, ref_x(ta, lut_in));
      check("R5", out_y, ref_y(ta, tb, sel5, lut_in));
    end
    // R6: ce low holds across changed inputs
    e = ref_x(ta, lut_in);
    ce = 1'b0;
    lut_in = ~lut_in;
    sel5 = ~sel5;
    repeat (3) @(negedge clk);
    check("R6", out_x, e);
    // R7: sr with ce high loads reset value 1
    ce = 1'b1;
    sr = 1'b1;
    @(negedge clk);
    check("R7", out_x, 1'b1);
    check("R7", out_y, 1'b1);
    sr = 1'b0;
    ce = 1'b0;
    load(ta, tb, 1'b0, 1'b0, 1'b0);
    sr = 1'b1;
    @(negedge clk);
    check("R7", out_x, 1'b0);
    check("R7", out_y, 1'b0);
    sr = 1'b0;

    // R8: load while ce and sr high; regs must hold 0 through reload
    ce = 1'b1;
    sr = 1'b1;
    fork
      load(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1);
    join
    ce = 1'b0;
    sr = 1'b0;
    #1;
    check("R8", out_x, 1'b0);
    check("R8", out_y, 1'b0);
    // then capture works with the new tables
    ce = 1'b1;
    @(negedge clk);
    check("R5", out_x, 1'b1);
    check("R5", out_y, 1'b1);
    ce = 1'b0;

    // R1: mid-run reset clears the chain, outputs back to 0
    rst_n = 1'b0;
    #1;
    check("R1", out_x, 1'b0);
    check("R1", out_y, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule